// File: doc/BRIEF.md
# DMA Protected Memory Region Filter

This block sits in the inbound DMA path and checks every request against two protected windows in memory: a low window and a high window. Each window is a base page and a limit page, both inclusive, at 4 KB granularity. A single enable bit in a control word turns protection on. The same word carries a status bit that reports when protection has actually taken effect. The status bit is held back until the in-flight translated traffic has drained.

The decision to block is combinational. It is made in the same cycle as the request. It depends on four things: whether the request hits a window, whether DMA remapping is globally on, the translation type of the request's context, and the request's own address type. Requests that the remapping engine makes to reach its own structures are never checked. A request that is blocked here never produces a remapping fault report.

Software programs the block through a small word-addressed register port with a combinational read path. Two capability inputs state which windows the platform supports. If neither window is supported, the control word is read-only.

Top module: `dma_prot_filter`

## Requirements
- R1: The register port decodes `reg_addr` as follows: 0 is the control word, 1 is the low base, 2 is the low limit, 3 is the high base and 4 is the high limit. Any other index reads zero. In the control word, bit 31 is the read-write enable, bit 0 is the read-only status and bits 30:1 always read zero. Base and limit registers hold a page number, which is address bits AW-1:12, in their low bits and read back zero-extended. Every register resets to zero.
- R2: While the enable bit is 0, `req_block` stays low for every request.
- R3: A window hits when base <= page <= limit, where page is `req_addr[AW-1:12]`. A window whose limit is below its base hits nothing. The low window can hit only while `cap_low` is 1, and the high window only while `cap_high` is 1.
- R4: With the enable bit set and `remap_en` low, every valid request that hits a window is blocked.
- R5: With the enable bit set and `remap_en` high, a hitting request is blocked when `ctx_tt` is 2'b10 (pass-through) or `req_at` is 2'b10 (already translated). All other hitting requests pass.
- R6: A request with `req_hw` high (remapping hardware reaching its own structures) is never blocked.
- R7: `fault_report` equals `xlat_fault` for a request that is not blocked, and is 0 for a blocked request.
- R8: The status bit becomes 1 only at a clock edge where the enable bit is already 1 and `inflight_zero` is 1. After that it stays 1 while the enable bit stays 1.
- R9: At the first clock edge after the enable bit is cleared, the status bit drops to 0, with no drain wait.
- R10: While `cap_low` and `cap_high` are both 0, writes to the control word leave the enable bit unchanged.
- R11: `req_block` is 0 whenever `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cap_low | input | 1 | Low window supported |
| cap_high | input | 1 | High window supported |
| inflight_zero | input | 1 | No translated request is in flight |
| remap_en | input | 1 | DMA remapping globally enabled |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request address |
| req_at | input | 2 | Request address type (2'b10 = translated) |
| ctx_tt | input | 2 | Context translation type (2'b10 = pass-through) |
| req_hw | input | 1 | Access by the remapping hardware to its own structures |
| xlat_fault | input | 1 | Remapping fault raised for this request |
| req_block | output | 1 | Request is blocked by a protected window |
| fault_report | output | 1 | Fault forwarded to fault reporting |

## Verification
The bench sweeps every page of a 16-page address space. For each page it tries every combination of remapping state, translation type, address type and hardware-access flag, with the edge pages of each window included. An off-by-one compare would block the page just outside a window or pass the last page inside it. Blocking keyed on the wrong mode field would leak pass-through or translated traffic, or would block requests that are being remapped. Further runs use an inverted window and a missing capability bit: a design that failed to treat these as empty would block traffic it should not. The enable sequencing is tested with the drain input held low for several cycles, so a status bit set too early shows up. A clear that waits for drain, or enable writes that are accepted without any capability, show up in the control word as read back.

// File: rtl/dma_prot_filter.sv
module dma_prot_filter #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          cap_low,
  input  logic          cap_high,
  input  logic          inflight_zero,
  input  logic          remap_en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_at,
  input  logic [1:0]    ctx_tt,
  input  logic          req_hw,
  input  logic          xlat_fault,
  output logic          req_block,
  output logic          fault_report
);
  localparam int PW = AW - 12;
  localparam logic [1:0] TT_PASS = 2'b10;
  localparam logic [1:0] AT_XLAT = 2'b10;

  logic          en_q, prs_q;
  logic [PW-1:0] lo_base, lo_lim, hi_base, hi_lim;
  logic [PW-1:0] page;
  logic          lo_hit, hi_hit, mode_blk;
  logic          any_cap;

  assign any_cap = cap_low | cap_high;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lo_base <= '0;
      lo_lim  <= '0;
      hi_base <= '0;
      hi_lim  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: if (any_cap) en_q <= reg_wdata[31];
        3'd1: lo_base <= reg_wdata[PW-1:0];
        3'd2: lo_lim  <= reg_wdata[PW-1:0];
        3'd3: hi_base <= reg_wdata[PW-1:0];
        3'd4: hi_lim  <= reg_wdata[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prs_q <= 1'b0;
    else        prs_q <= en_q & (prs_q | inflight_zero);
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {en_q, 30'b0, prs_q};
      3'd1:    reg_rdata = {{(32-PW){1'b0}}, lo_base};
      3'd2:    reg_rdata = {{(32-PW){1'b0}}, lo_lim};
      3'd3:    reg_rdata = {{(32-PW){1'b0}}, hi_base};
      3'd4:    reg_rdata = {{(32-PW){1'b0}}, hi_lim};
      default: reg_rdata = '0;
    endcase
  end

  assign page     = req_addr[AW-1:12];
  assign lo_hit   = cap_low  & (page >= lo_base) & (page <= lo_lim);
  assign hi_hit   = cap_high & (page >= hi_base) & (page <= hi_lim);
  assign mode_blk = ~remap_en | (ctx_tt == TT_PASS) | (req_at == AT_XLAT);

  assign req_block    = req_valid & en_q & ~req_hw & (lo_hit | hi_hit) & mode_blk;
  assign fault_report = xlat_fault & ~req_block;
endmodule

// File: rtl/dma_prot_filter_chk.sv
module dma_prot_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic prs_q,
  input logic cap_low,
  input logic cap_high,
  input logic inflight_zero,
  input logic req_valid,
  input logic req_hw,
  input logic req_block,
  input logic xlat_fault,
  input logic fault_report
);
  assert_off_no_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !req_block);
  assert_hw_never_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_hw |-> !req_block);
  assert_blocked_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_block |-> !fault_report);
  assert_fault_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_fault && !req_block) |-> fault_report);
  assert_status_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prs_q) |-> ($past(en_q) && $past(inflight_zero)));
  assert_status_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |=> !prs_q);
  assert_status_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prs_q |-> $past(en_q));
  assert_nocap_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_low && !cap_high) |=> $stable(en_q));
  assert_idle_no_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_block);
endmodule

bind dma_prot_filter dma_prot_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .prs_q(prs_q),
  .cap_low(cap_low), .cap_high(cap_high), .inflight_zero(inflight_zero),
  .req_valid(req_valid), .req_hw(req_hw), .req_block(req_block),
  .xlat_fault(xlat_fault), .fault_report(fault_report)
);

// File: tb/dma_prot_filter_tb_top.sv
module dma_prot_filter_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic cap_low = 1, cap_high = 1, inflight_zero = 1, remap_en = 0;
  logic req_valid = 0, req_hw = 0, xlat_fault = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0] req_at = 0, ctx_tt = 0;
  logic req_block, fault_report;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_prot_filter #(.AW(AW)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic sweep(input bit en, input int lb, input int ll, input int hb, input int hl, input string tag);
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 64; m++) begin
        bit rm, hw, v, hit, eb;
        logic [1:0] tt, at;
        rm = m[0]; hw = m[1]; tt = m[3:2]; at = m[5:4];
        v = (p % 3) != 2 || m[0];
        @(negedge clk);
        req_valid = v; remap_en = rm; req_hw = hw; ctx_tt = tt; req_at = at;
        req_addr = {p[3:0], 12'hA5C};
        xlat_fault = 1;
        #1;
        hit = (cap_low && p >= lb && p <= ll) || (cap_high && p >= hb && p <= hl);
        eb = v && en && !hw && hit && (!rm || tt == 2'b10 || at == 2'b10);
        check(req_block === eb, tag, {31'b0, req_block}, {31'b0, eb});
        check(fault_report === !eb, {tag, " R7"}, {31'b0, fault_report}, {31'b0, !eb});
      end
    @(negedge clk);
    req_valid = 0; xlat_fault = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 8; a++) rd_check(a[2:0], 32'h0, "R1 reset");
    wr(1, 32'hFFFF_FFF3); wr(2, 6); wr(3, 10); wr(4, 12);
    rd_check(1, 32'h3, "R1 base width");
    rd_check(2, 32'h6, "R1 lo lim");
    rd_check(3, 32'hA, "R1 hi base");
    rd_check(4, 32'hC, "R1 hi lim");
    // R2 and R11 disabled sweep
    sweep(0, 3, 6, 10, 12, "R2 R11 disabled");
    // R1 and R8: reserved bits read zero, status one cycle later
    wr(0, 32'hFFFF_FFFF);
    rd_check(0, 32'h8000_0000, "R1 R8 enable only");
    @(negedge clk);
    rd_check(0, 32'h8000_0001, "R8 status set");
    // R3 R4 R5 R6 R7 enabled sweep
    sweep(1, 3, 6, 10, 12, "R3 R4 R5 R6 enabled");
    // R3 inverted low window and missing high capability
    wr(1, 9); wr(2, 5);
    cap_high = 0;
    sweep(1, 9, 5, 10, 12, "R3 empty window");
    cap_high = 1;
    // R9 clear
    wr(0, 32'h0);
    @(negedge clk);
    rd_check(0, 32'h0, "R9 status cleared");
    // R8 drain wait
    inflight_zero = 0;
    wr(0, 32'h8000_0000);
    repeat (5) @(negedge clk);
    rd_check(0, 32'h8000_0000, "R8 drain pending");
    inflight_zero = 1;
    @(negedge clk);
    rd_check(0, 32'h8000_0001, "R8 drained");
    inflight_zero = 0;
    repeat (2) @(negedge clk);
    rd_check(0, 32'h8000_0001, "R8 status held");
    inflight_zero = 1;
    // R10 no capability: writes ignored
    cap_low = 0; cap_high = 0;
    wr(0, 32'h0);
    @(negedge clk);
    rd_check(0, 32'h8000_0001, "R10 clear ignored");
    cap_low = 1;
    wr(0, 32'h0);
    cap_low = 0;
    @(negedge clk);
    wr(0, 32'h8000_0000);
    @(negedge clk);
    rd_check(0, 32'h0, "R10 set ignored");
    rd_check(7, 32'h0, "R1 unmapped index");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule